// File: doc/BRIEF.md
# Shared-Memory Multicycle CPU Sequencer

A small non-pipelined 32-bit core. One single-port memory holds both code and data, so the core never fetches and accesses data in the same cycle. The memory returns read data one clock after it sees an address. A three-state controller steps each instruction through a fetch cycle, an execute cycle and, for loads and stores only, a memory cycle. The core also holds the program counter, a sixteen-entry register file and an adder-based ALU.

Each instruction word is decoded from fixed fields. The opcode is in bits [31:28], the destination register in [27:24], the first source in [23:20] and the second source in [19:16]. A signed 16-bit immediate sits in [15:0]. The supported opcodes are 0 (register add), 1 (immediate add), 2 (word load rd ← mem[rs1+imm]), 3 (word store mem[rs1+imm] ← rs2) and 4 (branch to pc+imm when rs1 equals rs2). A one-cycle retire pulse marks the last cycle of every instruction, so its spacing shows the 2-cycle and 3-cycle latencies.

Top module: `mcpu_core`

## Requirements
- R1: While rst_ni is low the controller is in the fetch state with pc = 0. In the first cycle after release mem_addr_o = 0, mem_we_o = 0 and retire_o = 0.
- R2: In every fetch cycle mem_addr_o equals pc, mem_we_o is 0 and retire_o is 0.
- R3: Memory read data is taken exactly one cycle after the address is driven. The instruction is used in the cycle after fetch, and load data is used in the cycle after the load address.
- R4: Opcodes 0 and 1 finish in the second cycle, with retire_o high there and the sum written to rd in that cycle.
- R5: A load (opcode 2) drives mem_addr_o = rs1 + sext(imm) in cycle 2 with retire_o = 0. In cycle 3 it writes mem_rdata_i to rd with retire_o = 1.
- R6: A store (opcode 3) computes the address and reads rs2 in cycle 2. In cycle 3 it drives mem_we_o = 1, mem_addr_o = rs1 + sext(imm) and mem_wdata_o = the rs2 value, with retire_o = 1.
- R7: mem_we_o is high only in the third cycle of a store. The next fetch starts only in the cycle after retire_o.
- R8: pc advances by 4 when an instruction completes. An opcode 4 whose sources are equal instead loads pc + sext(imm), and opcode 4 always finishes in 2 cycles.
- R9: Register 0 reads as zero, and writes addressed to it have no effect.
- R10: retire_o is high for exactly one cycle per instruction.
- R11: Opcodes 5 to 15 complete in 2 cycles as no-ops that only advance pc by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_addr_o | output | 32 | Byte address to the shared memory |
| mem_we_o | output | 1 | Write strobe for a full word |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Read data, valid one cycle after its address |
| retire_o | output | 1 | One-cycle pulse in the final cycle of each instruction |

## Verification
A wrong controller state shows up at the ports within one cycle. mem_addr_o stops tracking pc in what should be a fetch cycle, or retire_o and mem_we_o appear in the wrong cycle. A wrong pc or register value shows up at the next fetch address, or at the next store that uses the register. That is at most a few instructions later, and the program is written so that every computed register soon reaches a store. Retire spacing then exposes any change in the 2-cycle or 3-cycle latency.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;
  localparam int REG_AW = 4;
  localparam int NREG   = 1 << REG_AW;
  localparam int IMM_W  = 16;

  typedef enum logic [1:0] {ST_FETCH = 2'd0, ST_EXEC = 2'd1, ST_MEM = 2'd2} state_e;

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_ADDI = 4'd1;
  localparam logic [3:0] OP_LW   = 4'd2;
  localparam logic [3:0] OP_SW   = 4'd3;
  localparam logic [3:0] OP_BEQ  = 4'd4;
endpackage

// File: rtl/mcpu_regfile.sv
module mcpu_regfile #(
  parameter int XLEN = 32,
  parameter int AW   = 4,
  localparam int N   = 1 << AW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   ra_i,
  input  logic [AW-1:0]   rb_i,
  output logic [XLEN-1:0] a_o,
  output logic [XLEN-1:0] b_o,
  input  logic            we_i,
  input  logic [AW-1:0]   wa_i,
  input  logic [XLEN-1:0] wd_i
);
  logic [XLEN-1:0] regs [N];

  assign regs[0] = '0;  // hardwired zero, never stored

  for (genvar i = 1; i < N; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           regs[i] <= '0;
      else if (we_i && wa_i == AW'(i))       regs[i] <= wd_i;
    end
  end

  assign a_o = regs[ra_i];
  assign b_o = regs[rb_i];
endmodule

// File: rtl/mcpu_alu.sv
module mcpu_alu #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic            use_imm_i,
  output logic [XLEN-1:0] sum_o,
  output logic            eq_o
);
  assign sum_o = a_i + (use_imm_i ? imm_i : b_i);
  assign eq_o  = (a_i == b_i);
endmodule

// File: rtl/mcpu_ctrl.sv
module mcpu_ctrl
  import mcpu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] op_i,
  output state_e     state_o,
  output logic       retire_o,
  output logic       mem_we_o,
  output logic       rf_alu_we_o,
  output logic       rf_ld_we_o
);
  state_e state_q, state_d;
  logic   is_mem;

  assign is_mem = (op_i == OP_LW) || (op_i == OP_SW);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH: state_d = ST_EXEC;
      ST_EXEC:  state_d = is_mem ? ST_MEM : ST_FETCH;
      default:  state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  assign state_o     = state_q;
  assign retire_o    = (state_q == ST_EXEC && !is_mem) || (state_q == ST_MEM);
  assign mem_we_o    = (state_q == ST_MEM) && (op_i == OP_SW);
  assign rf_alu_we_o = (state_q == ST_EXEC) && (op_i == OP_ADD || op_i == OP_ADDI);
  assign rf_ld_we_o  = (state_q == ST_MEM) && (op_i == OP_LW);

  a_r3_fetch_then_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_FETCH |=> state_q == ST_EXEC);
  a_r5_mem_then_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_MEM |=> state_q == ST_FETCH);
  a_r7_we_only_in_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> state_q == ST_MEM);
  a_r7_fetch_after_retire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |=> state_q == ST_FETCH);
endmodule

// File: rtl/mcpu_core.sv
module mcpu_core
  import mcpu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] mem_addr_o,
  output logic            mem_we_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic            retire_o
);
  localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

  state_e            state;
  logic [XLEN-1:0]   pc_q, ir_q, ea_q, sd_q, instr, imm, rs1_v, rs2_v, alu_sum, rf_wd;
  logic [3:0]        op;
  logic [REG_AW-1:0] rd, rs1, rs2;
  logic              alu_eq, rf_alu_we, rf_ld_we, take_br, sel_data;

  // instruction arrives on the read port in EXEC, held in ir_q afterwards
  assign instr = (state == ST_EXEC) ? mem_rdata_i : ir_q;
  assign op    = instr[31:28];
  assign rd    = instr[27:24];
  assign rs1   = instr[23:20];
  assign rs2   = instr[19:16];
  assign imm   = {{(XLEN-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};

  mcpu_ctrl i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op),
    .state_o     (state),
    .retire_o    (retire_o),
    .mem_we_o    (mem_we_o),
    .rf_alu_we_o (rf_alu_we),
    .rf_ld_we_o  (rf_ld_we)
  );

  assign rf_wd = rf_ld_we ? mem_rdata_i : alu_sum;

  mcpu_regfile #(.XLEN(XLEN), .AW(REG_AW)) i_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_i   (rs1),
    .rb_i   (rs2),
    .a_o    (rs1_v),
    .b_o    (rs2_v),
    .we_i   (rf_alu_we | rf_ld_we),
    .wa_i   (rd),
    .wd_i   (rf_wd)
  );

  mcpu_alu #(.XLEN(XLEN)) i_alu (
    .a_i       (rs1_v),
    .b_i       (rs2_v),
    .imm_i     (imm),
    .use_imm_i (op != OP_ADD),
    .sum_o     (alu_sum),
    .eq_o      (alu_eq)
  );

  assign take_br  = (state == ST_EXEC) && (op == OP_BEQ) && alu_eq;
  assign sel_data = (state != ST_FETCH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      ir_q <= '0;
      ea_q <= '0;
      sd_q <= '0;
    end else begin
      if (state == ST_EXEC) begin
        ir_q <= mem_rdata_i;
        ea_q <= alu_sum;
        sd_q <= rs2_v;
      end
      if (retire_o) pc_q <= take_br ? pc_q + imm : pc_q + PC_STEP;
    end
  end

  always_comb begin
    if (!sel_data)              mem_addr_o = pc_q;
    else if (state == ST_EXEC)  mem_addr_o = alu_sum;
    else                        mem_addr_o = ea_q;
  end
  assign mem_wdata_o = sd_q;

  a_r8_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o && !take_br |=> pc_q == $past(pc_q) + PC_STEP);
  a_r10_retire_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |=> !retire_o);
  a_r2_no_write_on_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_FETCH |-> !mem_we_o && !retire_o);
endmodule

// File: tb/test_mcpu_core.sv
module test_mcpu_core;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYC    = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr, wdata, rdata;
  logic        we, retire;
  logic [31:0] mem [64];
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcpu_core i_mcpu_core (
    .clk_i(clk), .rst_ni(rst_n), .mem_addr_o(addr), .mem_we_o(we),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata), .retire_o(retire));

  // single-port memory, one-cycle read latency
  always @(posedge clk) begin
    rdata <= mem[addr[7:2]];
    if (we) mem[addr[7:2]] <= wdata;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(int op, int rd, int rs1, int rs2, int imm);
    return {4'(op), 4'(rd), 4'(rs1), 4'(rs2), 16'(imm)};
  endfunction

  // behavioural reference model
  int          m_phase = 0, cyc = 0, last_ret = 0, n_ret = 0;
  logic [31:0] m_pc = 0, m_ea = 0, m_wd = 0;
  logic [3:0]  m_op = 0, m_rd = 0;
  logic [31:0] m_rf [16];
  int          lat [32];

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (retire) begin
        if (n_ret < 32) lat[n_ret] = cyc - last_ret;
        n_ret++;
        last_ret = cyc;
      end
      case (m_phase)
        0: begin
          chk("R2 fetch addr", addr, m_pc);
          chk("R2 fetch we", 32'(we), 0);
          chk("R2 fetch retire", 32'(retire), 0);
          m_phase = 1;
        end
        1: begin
          logic [31:0] ins, a, b, imm, ea;
          logic [3:0]  op, rd;
          ins = mem[m_pc[7:2]];
          op = ins[31:28]; rd = ins[27:24];
          a = m_rf[ins[23:20]]; b = m_rf[ins[19:16]];
          imm = {{16{ins[15]}}, ins[15:0]};
          ea = a + imm;
          chk("R7 exec we", 32'(we), 0);
          if (op == 2 || op == 3) begin
            chk("R5/R6 exec addr", addr, ea);
            chk("R5/R6 exec retire", 32'(retire), 0);
            m_ea = ea; m_wd = b; m_op = op; m_rd = rd;
            m_phase = 2;
          end else begin
            chk("R4/R8/R11 exec retire", 32'(retire), 1);
            if (op == 0 && rd != 0) m_rf[rd] = a + b;
            if (op == 1 && rd != 0) m_rf[rd] = a + imm;
            m_pc = (op == 4 && a == b) ? m_pc + imm : m_pc + 4;
            m_phase = 0;
          end
        end
        default: begin
          chk("R5/R6 mem addr", addr, m_ea);
          chk("R6/R7 mem we", 32'(we), 32'(m_op == 3));
          chk("R5/R6 mem retire", 32'(retire), 1);
          if (m_op == 3) chk("R6 store data", wdata, m_wd);
          if (m_op == 2 && m_rd != 0) m_rf[m_rd] = mem[m_ea[7:2]];
          m_pc = m_pc + 4;
          m_phase = 0;
        end
      endcase
    end
  end

  int exp_lat [17] = '{2,2,2,3,3,2,3,2,3,2,2,2,2,3,3,3,2};

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    for (int i = 0; i < 16; i++) m_rf[i] = 32'h0;
    mem[0]  = enc(1, 1, 0, 0, 5);       // x1 = 5
    mem[1]  = enc(1, 2, 0, 0, 192);     // x2 = 192
    mem[2]  = enc(0, 3, 1, 1, 0);       // x3 = 10
    mem[3]  = enc(3, 0, 2, 3, 0);       // [192] = x3
    mem[4]  = enc(2, 4, 2, 0, 0);       // x4 = [192]
    mem[5]  = enc(1, 0, 1, 0, 7);       // x0 write ignored
    mem[6]  = enc(3, 0, 2, 0, 4);       // [196] = x0
    mem[7]  = enc(0, 5, 4, 1, 0);       // x5 = 15
    mem[8]  = enc(3, 0, 2, 5, 8);       // [200] = x5
    mem[9]  = enc(4, 0, 1, 1, 8);       // taken -> 44
    mem[10] = enc(1, 6, 0, 0, 99);      // skipped
    mem[11] = enc(4, 0, 1, 3, 8);       // not taken
    mem[12] = enc(15, 6, 0, 0, 1);      // no-op opcode
    mem[13] = enc(1, 7, 0, 0, -4);      // x7 = -4
    mem[14] = enc(3, 0, 2, 7, 12);      // [204] = x7
    mem[15] = enc(2, 8, 2, 0, -4);      // x8 = [188]
    mem[16] = enc(3, 0, 2, 8, 16);      // [208] = x8
    mem[17] = enc(4, 0, 0, 0, 0);       // spin
    mem[47] = 32'h0000_1234;

    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset addr", addr, 0);
    chk("R1 reset we", 32'(we), 0);
    chk("R1 reset retire", 32'(retire), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int c = 0; c < RUN_CYC; c++) begin
      @(posedge clk);
      if (cyc - last_ret > 8) begin
        n_chk++; n_err++;
        $display("FAIL R10 watchdog: no retire actual=%0d expected<=3", cyc - last_ret);
        break;
      end
    end
    @(negedge clk);

    for (int i = 0; i < 17; i++) chk("R4/R5/R6/R8 latency", 32'(lat[i]), 32'(exp_lat[i]));
    chk("R6 stored sum", mem[48], 32'd10);
    chk("R9 x0 stays zero", mem[49], 32'd0);
    chk("R5 loaded value used", mem[50], 32'd15);
    chk("R4 negative immediate", mem[51], 32'hFFFF_FFFC);
    chk("R3 load negative offset", mem[52], 32'h0000_1234);
    chk("R8 spin pc", m_pc, 32'd68);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule